// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block sends asynchronous serial frames on a single line. Software places a word in a one-entry holding buffer. When the shift stage is free the word moves into it, and the buffer is then open for the next word. That lets two frames follow each other with no idle time between them. Each frame has a low start bit, eight or nine data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. The bit period comes from a programmable divider.

An optional clear-to-send input, active low, decides when a new frame may start. It is checked when a frame is about to begin and again as each frame's last stop bit ends. A disable input freezes the bit clock and holds back new frames. Three flags report the state of the block: buffer empty, transmitter empty, and a sticky interrupt request. The request is raised either when the buffer empties or when the whole transmission completes, and software acknowledges it.

Top module: `sertx_buffered`

## Requirements
- R1: After reset `txd`=1, `buf_empty`=1, `tx_empty`=1 and `irq`=0.
- R2: Every bit lasts 16×(`div_n`+1) clock cycles, and the bit timer reloads at the start of every bit.
- R3: A frame is one low start bit, then the data bits with bit 0 first, then the stop bits, which are high.
- R4: When `nine_bit`=1 the frame carries nine data bits, and data bit 8 follows data bit 7. When `nine_bit`=0 it carries bits 0 to 7.
- R5: When `parity_en`=1 one parity bit follows the data. With `parity_odd`=0 the parity bit makes the number of ones across the data bits and the parity bit even. With `parity_odd`=1 it makes that number odd.
- R6: When `two_stop`=1 the frame ends with two high stop bits. Otherwise it ends with one.
- R7: A write (`wr_en`=1) is accepted only while `buf_empty`=1, and accepting it clears `buf_empty`. A write while `buf_empty`=0 has no effect. `buf_empty` returns to 1 in the cycle after the word moves into the shift stage.
- R8: `tx_empty` is 0 while a frame is being shifted out or a word is waiting in the buffer. It is 1 once the last stop bit has ended and the buffer is empty.
- R9: When `flow_en`=1 a frame starts only while `cts_n`, after a two-flop synchronizer, is low. A word that is still waiting when a stop bit ends with `cts_n` high stays in the buffer until `cts_n` goes low. When `flow_en`=0 a waiting word starts right at the end of the previous stop bit, with no idle time between the frames.
- R10: While `enable`=0 no frame starts, and a frame already in progress is frozen with `txd` held.
- R11: `irq` is set by the transfer of a word from the buffer when `irq_on_done`=0, and by the end of a frame with the buffer empty when `irq_on_done`=1. It stays set until `irq_clr`=1. A set and a clear in the same cycle leave it set.
- R12: `txd` is 1 whenever no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the divider's count source |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Transmit enable; 0 freezes the bit clock |
| div_n | input | DIV_W | Divider value n; a bit lasts 16(n+1) cycles |
| nine_bit | input | 1 | 1 selects nine data bits, 0 selects eight |
| parity_en | input | 1 | 1 adds a parity bit |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| two_stop | input | 1 | 1 selects two stop bits |
| flow_en | input | 1 | 1 gates frame starts with cts_n |
| irq_on_done | input | 1 | 1 raises the request when transmission completes, 0 when the buffer empties |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to transmit; bit 8 is used only in nine-bit mode |
| irq_clr | input | 1 | Clears the interrupt request |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| txd | output | 1 | Serial line out |
| buf_empty | output | 1 | Holding buffer is free |
| tx_empty | output | 1 | No frame in progress and no word waiting |
| irq | output | 1 | Sticky interrupt request |

## Verification
The interrupt request can be set and cleared by software in the same cycle. In buffer-empty mode, the bench writes a word and then drives `irq_clr` in exactly the cycle in which the word moves into the shift stage. It expects `irq` to read 1 afterwards. Two more things can also meet in one cycle: the end of a stop bit and the start of a waiting frame. The bench writes a second word while the first is still being sent. It then checks that the two start edges are exactly one frame length apart.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_W = 9;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_t;

    // Parity bit for the selected data length and sense
    function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                       input logic nine,
                                       input logic odd);
        logic p;
        p = ^d[7:0];
        if (nine) p = p ^ d[8];
        return p ^ odd;
    endfunction

endpackage

// File: rtl/sertx_sync.sv
module sertx_sync #(
    parameter int  STAGES    = 2,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= {STAGES{RST_VAL}};
        else     pipe <= {pipe[STAGES-2:0], din};
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 4;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;

    // 16*(n+1)-1 == 16*n + 15
    assign reload = {div_n, 4'hF};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= reload;
        end else if (run) begin
            if (cnt == '0) cnt <= reload;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
    import sertx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] start_word,
    input  frame_cfg_t        start_cfg,
    input  logic              tick,
    output logic              txd,
    output logic              busy,
    output logic              frame_end
);
    tx_state_t         state;
    logic [DATA_W-1:0] shreg;
    logic [3:0]        idx;
    logic [3:0]        last_idx;
    logic              nine_q, pe_q, two_q, par_q, stop2;

    assign last_idx = nine_q ? 4'd8 : 4'd7;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            idx    <= '0;
            nine_q <= 1'b0;
            pe_q   <= 1'b0;
            two_q  <= 1'b0;
            par_q  <= 1'b0;
            stop2  <= 1'b0;
        end else if (start) begin
            state  <= ST_START;
            shreg  <= start_word;
            idx    <= '0;
            nine_q <= start_cfg.nine;
            pe_q   <= start_cfg.par_en;
            two_q  <= start_cfg.two_stop;
            par_q  <= parity_of(start_word, start_cfg.nine, start_cfg.par_odd);
            stop2  <= 1'b0;
        end else if (tick) begin
            case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                    shreg <= shreg >> 1;
                    if (idx == last_idx) state <= pe_q ? ST_PAR : ST_STOP;
                    else                 idx   <= idx + 1'b1;
                end
                ST_PAR:  state <= ST_STOP;
                ST_STOP: begin
                    if (two_q && !stop2) stop2 <= 1'b1;
                    else                 state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (state)
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign frame_end = tick && (state == ST_STOP) && (!two_q || stop2);

    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (rst)
        start |=> !txd);  // R3

    AST_STOP_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STOP) |-> txd);  // R6
endmodule

// File: rtl/sertx_buffered.sv
module sertx_buffered
    import sertx_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_n,
    input  logic              nine_bit,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic              two_stop,
    input  logic              flow_en,
    input  logic              irq_on_done,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_clr,
    input  logic              cts_n,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_empty,
    output logic              irq
);
    logic              cts_s;
    logic              busy, frame_end, tick, load, cts_ok, irq_set;
    logic [DATA_W-1:0] hold;
    frame_cfg_t        cfg_now;

    assign cfg_now.nine     = nine_bit;
    assign cfg_now.par_en   = parity_en;
    assign cfg_now.par_odd  = parity_odd;
    assign cfg_now.two_stop = two_stop;

    sertx_sync #(.STAGES(2), .RST_VAL(1'b1)) u_cts_sync (
        .clk(clk), .rst(rst), .din(cts_n), .dout(cts_s)
    );

    sertx_bit_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst(rst), .run(enable && busy), .restart(load),
        .div_n(div_n), .tick(tick)
    );

    sertx_shifter u_shift (
        .clk(clk), .rst(rst), .start(load), .start_word(hold),
        .start_cfg(cfg_now), .tick(tick), .txd(txd), .busy(busy),
        .frame_end(frame_end)
    );

    assign cts_ok = !flow_en || !cts_s;
    assign load   = enable && !buf_empty && cts_ok && (!busy || frame_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_empty <= 1'b1;
            hold      <= '0;
        end else if (load) begin
            buf_empty <= 1'b1;
        end else if (wr_en && buf_empty) begin
            buf_empty <= 1'b0;
            hold      <= wr_data;
        end
    end

    assign irq_set = irq_on_done ? (frame_end && buf_empty) : load;

    always_ff @(posedge clk) begin
        if (rst)          irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    assign tx_empty = !busy && buf_empty;

    AST_LOAD_FREES_BUF: assert property (@(posedge clk) disable iff (rst)
        load |=> buf_empty);  // R7

    AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        !buf_empty |=> $stable(hold));  // R7

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> txd);  // R12

    AST_PAUSE_HOLDS_LINE: assert property (@(posedge clk) disable iff (rst)
        (!enable && busy) |=> $stable(txd));  // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);  // R11

    AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (flow_en && cts_s && !busy) |=> !busy);  // R9
endmodule

// File: tb/sertx_buffered_tb.sv
module sertx_buffered_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W      = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b1;
    logic [DIV_W-1:0] div_n = '0;
    logic nine_bit = 0, parity_en = 0, parity_odd = 0, two_stop = 0;
    logic flow_en = 0, irq_on_done = 0, wr_en = 0, irq_clr = 0, cts_n = 1;
    logic [8:0] wr_data = '0;
    logic txd, buf_empty, tx_empty, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_buffered #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .div_n(div_n),
        .nine_bit(nine_bit), .parity_en(parity_en), .parity_odd(parity_odd),
        .two_stop(two_stop), .flow_en(flow_en), .irq_on_done(irq_on_done),
        .wr_en(wr_en), .wr_data(wr_data), .irq_clr(irq_clr), .cts_n(cts_n),
        .txd(txd), .buf_empty(buf_empty), .tx_empty(tx_empty), .irq(irq)
    );

    typedef struct {
        logic [8:0] d;
        logic nine, pe, po, ts;
        int bl;
    } exp_t;

    exp_t sb[$];
    int   starts[$];
    int   total = 0, failed = 0, frames = 0, cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - failed, total);
    endtask

    task automatic send(input logic [8:0] d, input logic push);
        exp_t e;
        e.d = d; e.nine = nine_bit; e.pe = parity_en; e.po = parity_odd;
        e.ts = two_stop; e.bl = 16 * (int'(div_n) + 1);
        if (push) sb.push_back(e);
        wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_clr();
        irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0; @(negedge clk);
    endtask

    // Monitor: decode frames from txd and compare with the scoreboard
    initial begin
        exp_t e;
        int nb, ones;
        logic p;
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                starts.push_back(cyc);
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected frame", 1, 0);
                    e.d = '0; e.nine = 0; e.pe = 0; e.po = 0; e.ts = 0; e.bl = 16;
                end else begin
                    e = sb.pop_front();
                end
                nb = e.nine ? 9 : 8;
                repeat (e.bl/2) @(negedge clk);
                check(txd == 1'b0, "R2/R3 start bit", int'(txd), 0);
                ones = 0;
                for (int i = 0; i < nb; i++) begin
                    repeat (e.bl) @(negedge clk);
                    check(txd == e.d[i], (i == 8) ? "R4 data bit 8" : "R3 data bit",
                          int'(txd), int'(e.d[i]));
                    if (e.d[i]) ones++;
                end
                if (e.pe) begin
                    p = ((ones % 2) == 1) ^ ~e.po;
                    p = ~p;
                    // even: parity = ones odd ? 1 : 0 ; odd: inverted
                    p = ((ones % 2) == 1) ? ~e.po : e.po;
                    repeat (e.bl) @(negedge clk);
                    check(txd == p, "R5 parity bit", int'(txd), int'(p));
                end
                repeat (e.bl) @(negedge clk);
                check(txd == 1'b1, "R3 stop bit", int'(txd), 1);
                if (e.ts) begin
                    repeat (e.bl) @(negedge clk);
                    check(txd == 1'b1, "R6 second stop bit", int'(txd), 1);
                end
                frames++;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total++; failed++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int f0, gap;
        bit stayed_high;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R12 reset state
        check(txd == 1'b1, "R1 txd after reset", int'(txd), 1);
        check(buf_empty == 1'b1, "R1 buf_empty after reset", int'(buf_empty), 1);
        check(tx_empty == 1'b1, "R1 tx_empty after reset", int'(tx_empty), 1);
        check(irq == 1'b0, "R1 irq after reset", int'(irq), 0);

        // 8N1 with completion interrupt (R3, R7, R8, R11)
        irq_on_done = 1'b1;
        send(9'h0A5, 1'b1);
        check(tx_empty == 1'b0, "R8 tx_empty with word waiting", int'(tx_empty), 0);
        @(negedge clk);
        check(buf_empty == 1'b1, "R7 buf_empty after transfer", int'(buf_empty), 1);
        repeat (40) @(negedge clk);
        check(tx_empty == 1'b0, "R8 tx_empty mid frame", int'(tx_empty), 0);
        check(irq == 1'b0, "R11 no done irq mid frame", int'(irq), 0);
        wait_idle();
        check(irq == 1'b1, "R11 done irq after frame", int'(irq), 1);
        check(txd == 1'b1, "R12 idle line", int'(txd), 1);
        pulse_clr();
        check(irq == 1'b0, "R11 irq cleared", int'(irq), 0);

        // Parity even and odd (R5)
        parity_en = 1'b1; parity_odd = 1'b0;
        send(9'h03C, 1'b1); wait_idle();
        parity_odd = 1'b1;
        send(9'h03D, 1'b1); wait_idle();
        parity_en = 1'b0; parity_odd = 1'b0;

        // 9 data bits, two stop bits (R4, R6)
        nine_bit = 1'b1; two_stop = 1'b1;
        send(9'h1A5, 1'b1); wait_idle();
        nine_bit = 1'b1; parity_en = 1'b1;
        send(9'h100, 1'b1); wait_idle();
        nine_bit = 1'b0; two_stop = 1'b0; parity_en = 1'b0;

        // Slower divider (R2)
        div_n = 8'd1;
        send(9'h05A, 1'b1); wait_idle();
        div_n = 8'd0;

        // Back to back, write while full ignored (R7, R9)
        f0 = frames;
        send(9'h0C3, 1'b1);
        @(negedge clk);
        send(9'h03C, 1'b1);
        send(9'h0FF, 1'b0);
        check(buf_empty == 1'b0, "R7 buffer still full", int'(buf_empty), 0);
        wait_idle();
        check(frames - f0 == 2, "R7 full write ignored", frames - f0, 2);
        gap = starts[starts.size()-1] - starts[starts.size()-2];
        check(gap == 160, "R9 back to back frames", gap, 160);

        // CTS gating (R9)
        flow_en = 1'b1; cts_n = 1'b1;
        f0 = frames;
        send(9'h011, 1'b1);
        stayed_high = 1;
        repeat (200) begin @(negedge clk); if (!txd) stayed_high = 0; end
        check(stayed_high, "R9 no start while cts high", 0, 1);
        check(tx_empty == 1'b0, "R8 tx_empty with blocked word", int'(tx_empty), 0);
        cts_n = 1'b0;
        repeat (10) @(negedge clk);
        send(9'h022, 1'b1);
        cts_n = 1'b1;
        while (frames == f0) @(negedge clk);
        repeat (100) @(negedge clk);
        check(frames - f0 == 1, "R9 cts high at stop holds next", frames - f0, 1);
        check(buf_empty == 1'b0, "R9 word kept waiting", int'(buf_empty), 0);
        check(txd == 1'b1, "R12 line high while waiting", int'(txd), 1);
        cts_n = 1'b0;
        wait_idle();
        check(frames - f0 == 2, "R9 sent after cts low", frames - f0, 2);
        flow_en = 1'b0;

        // Disabled transmitter (R10)
        enable = 1'b0;
        f0 = frames;
        send(9'h077, 1'b1);
        stayed_high = 1;
        repeat (100) begin @(negedge clk); if (!txd) stayed_high = 0; end
        check(stayed_high, "R10 no start while disabled", 0, 1);
        check(buf_empty == 1'b0, "R10 word held while disabled", int'(buf_empty), 0);
        enable = 1'b1;
        wait_idle();
        check(frames - f0 == 1, "R10 sent after enable", frames - f0, 1);

        // Buffer-empty interrupt with a clear in the same cycle (R11)
        irq_on_done = 1'b0;
        pulse_clr();
        check(irq == 1'b0, "R11 irq clear before test", int'(irq), 0);
        wr_data = 9'h00F; wr_en = 1'b1;
        begin
            exp_t e;
            e.d = 9'h00F; e.nine = 0; e.pe = 0; e.po = 0; e.ts = 0; e.bl = 16;
            sb.push_back(e);
        end
        @(negedge clk);
        wr_en = 1'b0; irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(irq == 1'b1, "R11 set wins over clear", int'(irq), 1);
        wait_idle();

        check(sb.size() == 0, "R3 all frames seen", sb.size(), 0);
        summary();
        $finish;
    end
endmodule